// File: doc/BRIEF.md
# Drift-Predicting Cycle Time Counter

This block keeps a local time count, advancing one step per 40 ns tick, that a cycle master periodically overwrites with its own time. Resynchronising alone lets a local oscillator that is off frequency build a sawtooth phase error between updates. To shrink it, the block measures the phase error at each update (received time minus the local time just before the load) and feeds a scaled share of it into a signed, fixed-point correction expressed in ticks per cycle.

An external divider pulses `cycle_strobe` once per cycle, normally every 3125 ticks (125 us). On each pulse the correction is added to a fractional accumulator. When the accumulator reaches a whole tick, the counter gains one extra tick. When it falls to minus one whole tick, the counter holds for one tick. Either way the accumulator keeps the remainder. With 16 cycles between updates and a loop gain of 1/64, the correction changes by the phase error divided by 1024.

Top module: `drift_cycle_timer`

## Requirements
- R1: While `rst` is high, every output is zero on the next edge: `time_o`, `corr_o` and `err_o`. The fractional accumulator and the first-update flag are cleared too.
- R2: With `upd_valid` and `cycle_strobe` both low, `time_o` increases by exactly 1 per clock.
- R3: When `upd_valid` is high, `time_o` takes `upd_time` on the next edge. On that same edge, `err_o` takes `upd_time` minus the `time_o` value seen in that cycle. `err_o` changes at no other time.
- R4: The first update after reset loads the time and the error but leaves `corr_o` unchanged.
- R5: Each later update adds err × 2^FRAC_W / (N_CYC × A_INV) to `corr_o`. With the defaults (16 fractional bits, divisor 1024) this is err × 64, where `corr_o` counts ticks in units of 2^-16 tick. `corr_o` changes on no other edge.
- R6: A `cycle_strobe` without `upd_valid` adds `corr_o` to the accumulator. If the sum reaches +1 tick (65536), `time_o` advances by 2 instead of 1 and one tick is subtracted from the sum.
- R7: If that sum is at or below -1 tick, `time_o` keeps its value for that clock and one tick is added back to the sum.
- R8: When `upd_valid` and `cycle_strobe` are high in the same cycle, the update wins and the accumulator is left untouched.
- R9: The measured error saturates to the signed ERR_W range (+32767 / -32768 by default) when the true difference lies outside it.
- R10: `corr_o` is clamped to ±(2^FRAC_W − 1), so at most one whole-tick adjustment falls in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Tick clock (one tick per edge) |
| rst | input | 1 | Synchronous active-high reset |
| cycle_strobe | input | 1 | One-clock pulse at each cycle boundary |
| upd_valid | input | 1 | One-clock pulse carrying a received master time |
| upd_time | input | TIME_W | Master time delivered with `upd_valid` |
| time_o | output | TIME_W | Corrected local time |
| corr_o | output | FRAC_W+1 | Signed per-cycle correction, ticks with FRAC_W fraction bits |
| err_o | output | ERR_W | Last measured signed phase error in ticks |

## Verification
Several patterns are run. Idle ticks confirm plain counting. Runs of back-to-back cycle strobes follow a positive and then a negative correction: checking the count both one strobe before and at the strobe that crosses a whole tick separates a correct inserted or held tick from one that comes too early or too late. An update placed on the same clock as a strobe, after a partial accumulation, exposes any design that lets the strobe through, because the hold then shows up one strobe early. Updates far beyond the error range in both directions check error saturation and correction clamping, and a mid-run reset followed by a fresh update confirms that the first update never moves the correction.

// File: rtl/dct_pkg.sv
package dct_pkg;
  // Kind of whole-tick adjustment applied on a cycle boundary
  typedef enum logic [1:0] {
    ADJ_NONE   = 2'd0,
    ADJ_INSERT = 2'd1,
    ADJ_HOLD   = 2'd2
  } adj_e;
endpackage

// File: rtl/dct_err_meas.sv
// Phase error: received time minus local time, saturated to ERR_W bits.
module dct_err_meas #(
  parameter int TIME_W = 32,
  parameter int ERR_W  = 16
) (
  input  logic [TIME_W-1:0]       rx_time,
  input  logic [TIME_W-1:0]       loc_time,
  output logic signed [ERR_W-1:0] err
);
  logic signed [TIME_W-1:0] diff;
  assign diff = $signed(rx_time - loc_time);

  generate
    if (TIME_W > ERR_W) begin : g_clamp
      localparam logic signed [TIME_W-1:0] MAXV = TIME_W'((64'sd1 <<< (ERR_W-1)) - 1);
      localparam logic signed [TIME_W-1:0] MINV = -MAXV - TIME_W'(1);
      always_comb begin
        if (diff > MAXV)      err = ERR_W'(MAXV);
        else if (diff < MINV) err = ERR_W'(MINV);
        else                  err = ERR_W'(diff);
      end
    end else begin : g_extend
      assign err = $signed({{(ERR_W-TIME_W){diff[TIME_W-1]}}, diff});
    end
  endgenerate
endmodule

// File: rtl/dct_predictor.sv
// First-order drift predictor: corr += err * 2^FRAC_W / (N_CYC * A_INV), clamped.
module dct_predictor #(
  parameter int ERR_W  = 16,
  parameter int FRAC_W = 16,
  parameter int N_CYC  = 16,
  parameter int A_INV  = 64
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      load,
  input  logic signed [ERR_W-1:0]   err,
  output logic signed [FRAC_W:0]    corr_q
);
  localparam int SHIFT = $clog2(N_CYC) + $clog2(A_INV);
  localparam int WW    = ERR_W + FRAC_W + 2;
  localparam logic signed [WW-1:0] LIM = WW'((64'sd1 <<< FRAC_W) - 1);

  logic                 armed_q;
  logic signed [WW-1:0] err_w, corr_w, inc, sum;

  assign err_w  = $signed({{(WW-ERR_W){err[ERR_W-1]}}, err});
  assign corr_w = $signed({{(WW-FRAC_W-1){corr_q[FRAC_W]}}, corr_q});

  generate
    if (FRAC_W >= SHIFT) begin : g_up
      assign inc = err_w <<< (FRAC_W - SHIFT);
    end else begin : g_down
      assign inc = err_w >>> (SHIFT - FRAC_W);
    end
  endgenerate

  assign sum = corr_w + inc;

  always_ff @(posedge clk) begin
    if (rst) begin
      corr_q  <= '0;
      armed_q <= 1'b0;
    end else if (load) begin
      armed_q <= 1'b1;
      if (armed_q) begin
        if (sum > LIM)       corr_q <= (FRAC_W+1)'(LIM);
        else if (sum < -LIM) corr_q <= (FRAC_W+1)'(-LIM);
        else                 corr_q <= (FRAC_W+1)'(sum);
      end
    end
  end
endmodule

// File: rtl/dct_slip_acc.sv
// Fractional accumulator turning the per-cycle correction into whole-tick adjustments.
module dct_slip_acc
  import dct_pkg::*;
#(
  parameter int FRAC_W = 16
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   step,
  input  logic signed [FRAC_W:0] corr,
  output adj_e                   adj
);
  localparam int AW = FRAC_W + 2;
  localparam logic signed [AW-1:0] ONE = AW'(1) <<< FRAC_W;

  logic signed [AW-1:0] acc_q, sum;
  assign sum = acc_q + $signed({corr[FRAC_W], corr});

  always_comb begin
    adj = ADJ_NONE;
    if (step) begin
      if (sum >= ONE)       adj = ADJ_INSERT;
      else if (sum <= -ONE) adj = ADJ_HOLD;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      acc_q <= '0;
    end else if (step) begin
      case (adj)
        ADJ_INSERT: acc_q <= sum - ONE;
        ADJ_HOLD:   acc_q <= sum + ONE;
        default:    acc_q <= sum;
      endcase
    end
  end
endmodule

// File: rtl/drift_cycle_timer.sv
module drift_cycle_timer
  import dct_pkg::*;
#(
  parameter int TIME_W = 32,
  parameter int ERR_W  = 16,
  parameter int FRAC_W = 16,
  parameter int N_CYC  = 16,
  parameter int A_INV  = 64
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     cycle_strobe,
  input  logic                     upd_valid,
  input  logic [TIME_W-1:0]        upd_time,
  output logic [TIME_W-1:0]        time_o,
  output logic signed [FRAC_W:0]   corr_o,
  output logic signed [ERR_W-1:0]  err_o
);
  logic [TIME_W-1:0]       time_q;
  logic signed [ERR_W-1:0] err_d, err_q;
  adj_e                    adj;
  logic                    step;

  assign step = cycle_strobe && !upd_valid;

  dct_err_meas #(.TIME_W(TIME_W), .ERR_W(ERR_W)) u_meas (
    .rx_time (upd_time),
    .loc_time(time_q),
    .err     (err_d)
  );

  dct_predictor #(.ERR_W(ERR_W), .FRAC_W(FRAC_W), .N_CYC(N_CYC), .A_INV(A_INV)) u_pred (
    .clk   (clk),
    .rst   (rst),
    .load  (upd_valid),
    .err   (err_d),
    .corr_q(corr_o)
  );

  dct_slip_acc #(.FRAC_W(FRAC_W)) u_acc (
    .clk (clk),
    .rst (rst),
    .step(step),
    .corr(corr_o),
    .adj (adj)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      time_q <= '0;
      err_q  <= '0;
    end else if (upd_valid) begin
      time_q <= upd_time;
      err_q  <= err_d;
    end else begin
      case (adj)
        ADJ_INSERT: time_q <= time_q + TIME_W'(2);
        ADJ_HOLD:   time_q <= time_q;
        default:    time_q <= time_q + TIME_W'(1);
      endcase
    end
  end

  assign time_o = time_q;
  assign err_o  = err_q;
endmodule

// File: rtl/dct_checker.sv
module dct_checker #(
  parameter int TIME_W = 32,
  parameter int ERR_W  = 16,
  parameter int FRAC_W = 16
) (
  input logic                    clk,
  input logic                    rst,
  input logic                    cycle_strobe,
  input logic                    upd_valid,
  input logic [TIME_W-1:0]       upd_time,
  input logic [TIME_W-1:0]       time_o,
  input logic signed [FRAC_W:0]  corr_o,
  input logic signed [ERR_W-1:0] err_o
);
  localparam logic signed [FRAC_W:0] LIM = (FRAC_W+1)'((64'sd1 <<< FRAC_W) - 1);

  assert_reset_clear_R1: assert property (@(posedge clk)
    rst |=> (time_o == '0 && corr_o == '0 && err_o == '0));

  assert_plain_tick_R2: assert property (@(posedge clk) disable iff (rst)
    (!upd_valid && !cycle_strobe) |=> time_o == $past(time_o) + TIME_W'(1));

  assert_update_load_R3: assert property (@(posedge clk) disable iff (rst)
    upd_valid |=> time_o == $past(upd_time));

  assert_err_hold_R3: assert property (@(posedge clk) disable iff (rst)
    !upd_valid |=> $stable(err_o));

  assert_corr_hold_R5: assert property (@(posedge clk) disable iff (rst)
    !upd_valid |=> $stable(corr_o));

  assert_slip_step_R6: assert property (@(posedge clk) disable iff (rst)
    (cycle_strobe && !upd_valid) |=> (time_o == $past(time_o) ||
                                      time_o == $past(time_o) + TIME_W'(1) ||
                                      time_o == $past(time_o) + TIME_W'(2)));

  assert_corr_bound_R10: assert property (@(posedge clk) disable iff (rst)
    (corr_o <= LIM) && (corr_o >= -LIM));
endmodule

bind drift_cycle_timer dct_checker #(.TIME_W(TIME_W), .ERR_W(ERR_W), .FRAC_W(FRAC_W)) u_chk (
  .clk(clk), .rst(rst), .cycle_strobe(cycle_strobe), .upd_valid(upd_valid),
  .upd_time(upd_time), .time_o(time_o), .corr_o(corr_o), .err_o(err_o)
);

// File: tb/drift_cycle_timer_bench.sv
module drift_cycle_timer_bench;
  localparam int TIME_W = 32;
  localparam int ERR_W  = 16;
  localparam int FRAC_W = 16;

  typedef struct {
    int     sig;   // 0 time, 1 corr, 2 err
    longint val;
    string  tag;
  } exp_t;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cycle_strobe = 1'b0;
  logic upd_valid = 1'b0;
  logic [TIME_W-1:0] upd_time = '0;
  logic [TIME_W-1:0] time_o;
  logic signed [FRAC_W:0] corr_o;
  logic signed [ERR_W-1:0] err_o;

  int n_checks = 0;
  int n_fail = 0;
  bit done = 1'b0;
  exp_t sb[$];

  always #10 clk = ~clk;

  drift_cycle_timer u_drift_cycle_timer (
    .clk(clk), .rst(rst), .cycle_strobe(cycle_strobe), .upd_valid(upd_valid),
    .upd_time(upd_time), .time_o(time_o), .corr_o(corr_o), .err_o(err_o)
  );

  // Expectations describe outputs right after the next rising edge.
  task automatic expect_val(input int sig, input longint val, input string tag);
    exp_t e;
    e.sig = sig; e.val = val; e.tag = tag;
    sb.push_back(e);
  endtask

  // Drive inputs for one edge, then return at the following falling edge.
  task automatic step(input bit r, input bit u, input longint v, input bit c);
    rst = r; upd_valid = u; upd_time = TIME_W'(v); cycle_strobe = c;
    @(negedge clk);
    rst = 1'b0; upd_valid = 1'b0; cycle_strobe = 1'b0;
  endtask

  task automatic idle(input int n, input bit c);
    for (int i = 0; i < n; i++) step(1'b0, 1'b0, 0, c);
  endtask

  // Monitor: a quarter period after each rising edge
  always @(posedge clk) begin
    #5;
    while (sb.size() > 0) begin
      exp_t e;
      longint act;
      e = sb.pop_front();
      case (e.sig)
        0:       act = longint'(time_o);
        1:       act = longint'(corr_o);
        default: act = longint'(err_o);
      endcase
      n_checks++;
      if (act != e.val) begin
        n_fail++;
        $display("FAIL %s sig%0d actual=%0d expected=%0d", e.tag, e.sig, act, e.val);
      end
    end
  end

  initial begin
    @(negedge clk);
    step(1'b1, 1'b0, 0, 1'b0);
    expect_val(0, 0, "R1"); expect_val(1, 0, "R1"); expect_val(2, 0, "R1");
    step(1'b1, 1'b0, 0, 1'b0);
    // R2: five plain ticks
    idle(4, 1'b0);
    expect_val(0, 5, "R2");
    idle(1, 1'b0);
    // R3/R4: first update, correction untouched
    expect_val(0, 1000, "R3"); expect_val(2, 995, "R3"); expect_val(1, 0, "R4");
    step(1'b0, 1'b1, 1000, 1'b0);
    idle(9, 1'b0);
    expect_val(0, 1010, "R2");
    idle(1, 1'b0);
    // R5: error +64 -> correction 4096
    expect_val(0, 1074, "R3"); expect_val(2, 64, "R3"); expect_val(1, 4096, "R5");
    step(1'b0, 1'b1, 1074, 1'b0);
    // R6: sixteenth strobe inserts a tick
    idle(14, 1'b1);
    expect_val(0, 1089, "R6");
    idle(1, 1'b1);
    expect_val(0, 1091, "R6");
    idle(1, 1'b1);
    // R5: error -128 -> correction -4096
    expect_val(0, 963, "R3"); expect_val(2, -128, "R3"); expect_val(1, -4096, "R5");
    step(1'b0, 1'b1, 963, 1'b0);
    // R7: sixteenth strobe holds the time
    idle(14, 1'b1);
    expect_val(0, 978, "R7");
    idle(1, 1'b1);
    expect_val(0, 978, "R7");
    idle(1, 1'b1);
    // R8: partial accumulation, then update together with a strobe
    idle(3, 1'b1);
    expect_val(0, 981, "R8"); expect_val(2, 0, "R8"); expect_val(1, -4096, "R8");
    step(1'b0, 1'b1, 981, 1'b1);
    idle(11, 1'b1);
    expect_val(0, 993, "R8");
    idle(1, 1'b1);
    expect_val(0, 993, "R7");
    idle(1, 1'b1);
    // R9/R10: saturation both ways
    expect_val(2, 32767, "R9"); expect_val(1, 65535, "R10");
    step(1'b0, 1'b1, 100993, 1'b0);
    expect_val(2, -32768, "R9"); expect_val(1, -65535, "R10");
    step(1'b0, 1'b1, 993, 1'b0);
    // R1 again, then R4 after a fresh reset
    expect_val(0, 0, "R1"); expect_val(1, 0, "R1"); expect_val(2, 0, "R1");
    step(1'b1, 1'b0, 0, 1'b0);
    expect_val(0, 1, "R2");
    idle(1, 1'b0);
    expect_val(0, 50, "R3"); expect_val(2, 49, "R3"); expect_val(1, 0, "R4");
    step(1'b0, 1'b1, 50, 1'b0);
    idle(2, 1'b0);
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    #(20 * 200000);
    if (!done) begin
      done = 1'b1;
      n_checks++;
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end
endmodule